// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block decides which receive mailbox should take an incoming CAN frame. A frame is given by its 29-bit identifier field, an extended-format flag and a remote-request flag. Each mailbox is described by a 16-bit high identifier word, a 16-bit low identifier word, a 13-bit high mask, a 16-bit low mask, an enable bit and a direction bit. Every mailbox compares the frame against its own identifier in parallel. The block then returns two vectors: one with a bit set for every mailbox that accepts the frame, and a one-hot vector that marks the lowest-numbered accepting mailbox.

Frames enter through a valid/ready handshake. The result leaves through a second valid/ready handshake one clock after the frame is taken. A frame is taken on a rising edge where `in_valid` and `in_ready` are both high. The mailbox configuration is read on that same edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and no new frame is taken. Configuration pins are plain levels with no handshake.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: The high identifier word has this layout: bit 15 is the mask-enable flag, bit 14 is the extended flag, bit 13 is the remote flag, and bits 12:0 hold identifier bits. For a standard frame (`in_ide`=0), the 11 identifier bits `in_id[10:0]` are compared with high word bits 12:2. High word bits 1:0, the whole low word and `in_id[28:11]` play no part.
- R3: For an extended frame (`in_ide`=1), `in_id[28:16]` is compared with high word bits 12:0 and `in_id[15:0]` is compared with the low word.
- R4: When the mask-enable flag is 0, every compared identifier bit must be equal, and `in_rtr` must equal the remote flag.
- R5: When the mask-enable flag is 1, a mask bit of 1 (high mask bit k for high word bit k, low mask bit k for low word bit k) makes that identifier bit don't-care, and `in_rtr` is not compared. With all mask bits at 1, the mailbox accepts every identifier of its frame format.
- R6: A mailbox never accepts a frame whose `in_ide` differs from its extended flag, whatever its mask holds.
- R7: A mailbox whose `mb_enable` bit is 0, or whose `mb_rx` bit is 0 (transmit direction), never accepts.
- R8: `out_sel` has at most one bit set. That bit is the lowest-numbered set bit of `out_match`, and `out_sel` is all zero when nothing matches.
- R9: The result of a frame taken on an edge appears with `out_valid` high right after that edge. It reflects the configuration present on that edge.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_match` and `out_sel` stay stable. `in_ready` is 1 whenever `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame present |
| in_ready | output | 1 | Frame can be taken |
| in_id | input | 29 | Received identifier field |
| in_ide | input | 1 | Frame is extended format |
| in_rtr | input | 1 | Frame is a remote request |
| mb_hi | input | NUM_MBX*16 | High identifier words, mailbox i at [16i+15:16i] |
| mb_lo | input | NUM_MBX*16 | Low identifier words |
| mb_mask_hi | input | NUM_MBX*13 | High masks, 1 = ignore bit |
| mb_mask_lo | input | NUM_MBX*16 | Low masks, 1 = ignore bit |
| mb_enable | input | NUM_MBX | Mailbox enabled |
| mb_rx | input | NUM_MBX | 1 = receive direction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumer ready |
| out_match | output | NUM_MBX | Every accepting mailbox |
| out_sel | output | NUM_MBX | One-hot lowest accepting mailbox |

## Verification
The bench places junk in the bits a standard frame must ignore: high word bits 1:0, the low word and the upper identifier bits. A filter that compares the wrong field then drops standard frames that should match. It pairs an all-ones mask with a frame of the other format to catch a mask that hides the format check. It also pairs a remote frame with a mailbox set for data frames, in both exact and masked mode, to catch a remote flag that is always or never compared. Several mailboxes are made to match at once so that a priority picker favouring the highest index, or giving more than one hot bit, shows up. A stall test holds `out_ready` low while a new frame waits, to expose a design that overwrites or drops a result under back-pressure.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int ID_W    = 29;
  localparam int HI_W    = 16;
  localparam int LO_W    = 16;
  localparam int MHI_W   = 13;
  localparam int AME_BIT = 15;
  localparam int IDE_BIT = 14;
  localparam int RTR_BIT = 13;
  localparam int STD_W   = 11;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            ide;
    logic            rtr;
  } frame_t;
endpackage

// File: rtl/mbx_compare.sv
module mbx_compare
  import can_acc_pkg::*;
(
  input  frame_t            fr,
  input  logic [HI_W-1:0]   hi,
  input  logic [LO_W-1:0]   lo,
  input  logic [MHI_W-1:0]  mhi,
  input  logic [LO_W-1:0]   mlo,
  input  logic              en,
  input  logic              rx,
  output logic              hit
);
  localparam int PAD_W = MHI_W - STD_W;

  logic             ame;
  logic [MHI_W-1:0] f_hi;
  logic [MHI_W-1:0] care_hi;
  logic [LO_W-1:0]  care_lo;
  logic             id_ok;
  logic             fmt_ok;
  logic             rtr_ok;

  always_comb begin
    ame  = hi[AME_BIT];
    f_hi = fr.ide ? fr.id[ID_W-1:LO_W] : {fr.id[STD_W-1:0], {PAD_W{1'b0}}};
    care_hi = ame ? ~mhi : {MHI_W{1'b1}};
    if (!fr.ide) care_hi[PAD_W-1:0] = '0;
    care_lo = fr.ide ? (ame ? ~mlo : {LO_W{1'b1}}) : {LO_W{1'b0}};
    id_ok  = (((f_hi ^ hi[MHI_W-1:0]) & care_hi) == '0) &&
             (((fr.id[LO_W-1:0] ^ lo) & care_lo) == '0);
    fmt_ok = (hi[IDE_BIT] == fr.ide);
    rtr_ok = ame || (hi[RTR_BIT] == fr.rtr);
    hit    = en && rx && fmt_ok && rtr_ok && id_ok;
  end
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] grant
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_chain
    assign grant[g]  = req[g] & ~seen[g];
    assign seen[g+1] = seen[g] | req[g];
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_acc_pkg::*;
#(
  parameter int NUM_MBX = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ID_W-1:0]          in_id,
  input  logic                     in_ide,
  input  logic                     in_rtr,
  input  logic [NUM_MBX*HI_W-1:0]  mb_hi,
  input  logic [NUM_MBX*LO_W-1:0]  mb_lo,
  input  logic [NUM_MBX*MHI_W-1:0] mb_mask_hi,
  input  logic [NUM_MBX*LO_W-1:0]  mb_mask_lo,
  input  logic [NUM_MBX-1:0]       mb_enable,
  input  logic [NUM_MBX-1:0]       mb_rx,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NUM_MBX-1:0]       out_match,
  output logic [NUM_MBX-1:0]       out_sel
);
  frame_t             fr;
  logic [NUM_MBX-1:0] hits;
  logic [NUM_MBX-1:0] first;
  logic               take;

  assign fr       = '{id: in_id, ide: in_ide, rtr: in_rtr};
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar m = 0; m < NUM_MBX; m++) begin : g_mbx
    mbx_compare u_cmp (
      .fr  (fr),
      .hi  (mb_hi[m*HI_W +: HI_W]),
      .lo  (mb_lo[m*LO_W +: LO_W]),
      .mhi (mb_mask_hi[m*MHI_W +: MHI_W]),
      .mlo (mb_mask_lo[m*LO_W +: LO_W]),
      .en  (mb_enable[m]),
      .rx  (mb_rx[m]),
      .hit (hits[m])
    );
  end

  lowest_pick #(.W(NUM_MBX)) u_pick (
    .req   (hits),
    .grant (first)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_match <= '0;
      out_sel   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_match <= hits;
      out_sel   <= first;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NUM_MBX = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [NUM_MBX-1:0] mb_enable,
  input logic [NUM_MBX-1:0] mb_rx,
  input logic               out_valid,
  input logic               out_ready,
  input logic [NUM_MBX-1:0] out_match,
  input logic [NUM_MBX-1:0] out_sel
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_sel)); // R8
  AST_SEL_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_sel & ~out_match) == '0)); // R8
  AST_SEL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_match != '0)) |-> (out_sel != '0)); // R8
  AST_NO_IDLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((out_match & ~$past(mb_enable & mb_rx)) == '0)); // R7
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_match) && $stable(out_sel))); // R10
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R10
endmodule

bind can_accept_filter can_accept_filter_chk #(.NUM_MBX(NUM_MBX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mb_enable (mb_enable),
  .mb_rx     (mb_rx),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_match (out_match),
  .out_sel   (out_sel)
);

// File: tb/sim_can_accept_filter.sv
`timescale 1ns/1ps
module sim_can_accept_filter;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [28:0]   in_id = '0;
  logic          in_ide = 1'b0;
  logic          in_rtr = 1'b0;
  logic [N*16-1:0] mb_hi = '0;
  logic [N*16-1:0] mb_lo = '0;
  logic [N*13-1:0] mb_mask_hi = '0;
  logic [N*16-1:0] mb_mask_lo = '0;
  logic [N-1:0]  mb_enable = '0;
  logic [N-1:0]  mb_rx = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [N-1:0]  out_match;
  logic [N-1:0]  out_sel;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  can_accept_filter #(.NUM_MBX(N)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mb(input int i, input logic [15:0] hi, input logic [15:0] lo,
                        input logic [12:0] mh, input logic [15:0] ml, input bit en, input bit rx);
    mb_hi[i*16 +: 16]      = hi;
    mb_lo[i*16 +: 16]      = lo;
    mb_mask_hi[i*13 +: 13] = mh;
    mb_mask_lo[i*16 +: 16] = ml;
    mb_enable[i]           = en;
    mb_rx[i]               = rx;
  endtask

  function automatic bit model_hit(input int i);
    logic [15:0] hi = mb_hi[i*16 +: 16];
    logic [15:0] lo = mb_lo[i*16 +: 16];
    logic [12:0] mh = mb_mask_hi[i*13 +: 13];
    logic [15:0] ml = mb_mask_lo[i*16 +: 16];
    bit ame = hi[15];
    if (!mb_enable[i] || !mb_rx[i]) return 0;
    if (hi[14] != in_ide) return 0;
    if (!ame && hi[13] != in_rtr) return 0;
    if (!in_ide) begin
      for (int b = 0; b < 11; b++)
        if (!(ame && mh[b+2]) && in_id[b] != hi[b+2]) return 0;
    end else begin
      for (int b = 0; b < 29; b++) begin
        if (b < 16) begin
          if (!(ame && ml[b]) && in_id[b] != lo[b]) return 0;
        end else begin
          if (!(ame && mh[b-16]) && in_id[b] != hi[b-16]) return 0;
        end
      end
    end
    return 1;
  endfunction

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = model_hit(i);
    return v;
  endfunction

  function automatic logic [N-1:0] model_first(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  // Offer one frame with out_ready high, check result after the taking edge.
  task automatic send(input logic [28:0] id, input bit ide, input bit rtr, input string req);
    logic [N-1:0] ev, es;
    @(negedge clk);
    in_id = id; in_ide = ide; in_rtr = rtr; in_valid = 1'b1; out_ready = 1'b1;
    ev = model_vec();
    es = model_first(ev);
    @(posedge clk); #2;
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {req, " valid"}, 32'(out_valid), 1);
    chk(out_match === ev, {req, " match"}, 32'(out_match), 32'(ev));
    chk(out_sel === es, {req, " sel"}, 32'(out_sel), 32'(es));
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) @(posedge clk);
    #2;
    chk(out_valid === 1'b0, "R1 reset valid", 32'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 reset ready", 32'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk(out_valid === 1'b0, "R1 after reset", 32'(out_valid), 0);

    // R2 standard exact, junk in ignored fields
    for (int i = 0; i < N; i++) set_mb(i, '0, '0, '0, '0, 0, 1);
    set_mb(2, {3'b000, 11'h5a3, 2'b11}, 16'hbeef, '0, '0, 1, 1);
    send({18'h3ffff, 11'h5a3}, 0, 0, "R2 std exact");
    chk(out_sel === 8'h04, "R2 std sel mb2", 32'(out_sel), 32'h04);
    send({18'h0, 11'h5a2}, 0, 0, "R2 std one bit off");
    chk(out_match === '0, "R2 std miss", 32'(out_match), 0);

    // R3 extended exact
    set_mb(3, {3'b010, 13'h1abc}, 16'h1234, '0, '0, 1, 1);
    send({13'h1abc, 16'h1234}, 1, 0, "R3 ext exact");
    chk(out_match === 8'h08, "R3 ext hit", 32'(out_match), 32'h08);
    send({13'h1abc, 16'h1235}, 1, 0, "R3 ext low bit off");
    send({13'h0abc, 16'h1234}, 1, 0, "R3 ext high bit off");

    // R4 rtr compared in exact mode
    send({13'h1abc, 16'h1234}, 1, 1, "R4 rtr mismatch exact");
    chk(out_match === '0, "R4 rtr reject", 32'(out_match), 0);

    // R5 masked, all ones accepts every id of its format, rtr ignored
    set_mb(3, {3'b110, 13'h0}, 16'h0, 13'h1fff, 16'hffff, 1, 1);
    send(29'h1def_0123, 1, 1, "R5 mask all ext");
    chk(out_match === 8'h08, "R5 accept all", 32'(out_match), 32'h08);
    set_mb(3, {3'b110, 13'h1abc}, 16'h1234, 13'h0001, 16'h0100, 1, 1);
    send({13'h1abd, 16'h1334}, 1, 0, "R5 partial mask");

    // R6 format mismatch despite full mask
    set_mb(3, {3'b110, 13'h0}, 16'h0, 13'h1fff, 16'hffff, 1, 1);
    set_mb(2, '0, '0, '0, '0, 0, 1);
    send(29'h0000_0123, 0, 0, "R6 std vs ext mailbox");
    chk(out_match === '0, "R6 ide reject", 32'(out_match), 0);

    // R7 disabled and transmit mailboxes
    set_mb(3, {3'b110, 13'h0}, 16'h0, 13'h1fff, 16'hffff, 0, 1);
    set_mb(4, {3'b110, 13'h0}, 16'h0, 13'h1fff, 16'hffff, 1, 0);
    send(29'h0abc_dead, 1, 0, "R7 off and tx");
    chk(out_match === '0, "R7 no hit", 32'(out_match), 0);

    // R8 several matches, lowest wins
    set_mb(1, {3'b100, 13'h0}, 16'h0, 13'h1fff, 16'hffff, 1, 1);
    set_mb(5, {3'b100, 13'h0}, 16'h0, 13'h1fff, 16'hffff, 1, 1);
    set_mb(6, {3'b000, 11'h07f, 2'b00}, 16'h0, '0, '0, 1, 1);
    send(29'h07f, 0, 0, "R8 multi");
    chk(out_sel === 8'h02, "R8 lowest", 32'(out_sel), 32'h02);

    // R9/R10 stall: result held, next frame waits
    begin
      logic [N-1:0] hm, hs, ev;
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_id = 29'h07f; in_ide = 0; in_rtr = 0;
      @(posedge clk); #2;
      chk(out_valid === 1'b1, "R9 result next edge", 32'(out_valid), 1);
      hm = out_match; hs = out_sel;
      in_id = 29'h001;
      set_mb(1, '0, '0, '0, '0, 0, 1);
      repeat (3) begin
        @(posedge clk); #2;
        chk(in_ready === 1'b0, "R10 stall ready", 32'(in_ready), 0);
        chk(out_match === hm && out_sel === hs, "R10 hold", 32'(out_match), 32'(hm));
      end
      @(negedge clk);
      ev = model_vec();
      out_ready = 1'b1;
      @(posedge clk); #2;
      in_valid = 1'b0;
      chk(out_valid === 1'b1, "R10 drain take", 32'(out_valid), 1);
      chk(out_match === ev, "R10 new result", 32'(out_match), 32'(ev));
      @(posedge clk); #2;
      chk(out_valid === 1'b0, "R10 drained", 32'(out_valid), 0);
      chk(in_ready === 1'b1, "R10 idle ready", 32'(in_ready), 1);
    end

    // Random mix, R2..R8
    for (int t = 0; t < 400; t++) begin
      int k;
      logic [15:0] hk, lk;
      logic [28:0] id;
      bit ide, rtr;
      for (int i = 0; i < N; i++)
        set_mb(i, 16'($urandom), 16'($urandom),
               13'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
               ($urandom % 4) != 0, ($urandom % 4) != 0);
      k  = $urandom % N;
      hk = mb_hi[k*16 +: 16];
      lk = mb_lo[k*16 +: 16];
      id = 29'($urandom);
      ide = $urandom % 2;
      rtr = $urandom % 2;
      if ($urandom % 4 != 0) begin
        ide = hk[14];
        rtr = hk[13];
        id  = ide ? {hk[12:0], lk} : {18'($urandom), hk[12:2]};
        if ($urandom % 3 == 0) id[$urandom % 29] ^= 1'b1;
      end
      send(id, ide, rtr, "R2-R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule